// File: doc/BRIEF.md
# Interrupt Source Priority Register Bank

This block is the source side of an interrupt controller. A vector of single-bit interrupt wires enters the block, and each wire has its own source number. A per-source entry register sets that source's priority or masks it. The registers sit behind a plain 32-bit read/write bus that has three kinds of location:

- a configuration word at byte offset 0;
- a diagnostic word at byte offset 4;
- an array of per-source entries that starts at byte offset 0x800, one word every 4 bytes.

On every clock the block picks the most favoured unmasked source whose wire is high. It hands that source's global number and its priority to a downstream presentation stage. The global number is the fixed base of 16 plus the local index.

Software sets up the bank by writing a priority into each source's entry. It can read an entry back to see the live level of the input wire. The presentation stage watches the valid flag, the source number and the priority, and raises the processor interrupt from them.

Top module: `irq_src_bank`

## Requirements
- R1: A read of byte offset 0x000 returns the base number 16 in bits 23:0, the count of implemented priority bits (1 to 8, default 3) in bits 27:24, and zero in bits 31:28. With the defaults the word is 0x0300_0010. Writes to this offset change nothing.
- R2: A read of byte offset 0x004 returns the current level of input wire n in bit n, and zero in all bits at and above NUM_SRC. This location is read-only, so writes to it change nothing.
- R3: A read of the entry at byte offset 0x800 + 4n returns the current level of input n in both bit 31 and bit 29, and the priority in bits 7:0. Bit 30, bit 28, bits 27:20 and bits 19:8 read as zero.
- R4: A write to entry n keeps only the top PRIO_BITS bits of write data bits 7:0. The low 8-PRIO_BITS priority bits always read as one. With 3 bits, a write of 0x00 reads back 0x1F, a write of 0xA5 reads back 0xBF, and a write of 0xFF reads back 0xFF. All other write data bits are dropped.
- R5: After reset every entry priority reads 0xFF, the valid flag is low, and the read data bus is zero.
- R6: A source whose priority reads 0xFF is masked and is never presented, whatever its input level.
- R7: The outputs are registered. One clock after the inputs and priorities change, the outputs show the unmasked active source with the lowest priority value. On a tie the lowest source index wins. The source number is reported as 16 + n, and the priority as its 8-bit read-back value. The valid flag is high exactly when such a source exists.
- R8: Byte offsets that do not map to a register read as zero, and writes to them change no state. This covers offsets in the gap between 0x008 and 0x7FC, offsets that are not aligned to 4 bytes, and entry offsets at or beyond 0x800 + 4*NUM_SRC.
- R9: Read data appears on the clock edge that samples the read enable. It then holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busAddr | input | ADDR_W (12) | Byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| irqIn | input | NUM_SRC (8) | Level-sensitive interrupt inputs, synchronous to clk |
| irqValid | output | 1 | An unmasked source is active |
| irqSrcNum | output | 24 | Global number of the presented source |
| irqPrio | output | 8 | Priority of the presented source |

## Verification
The bench targets equal-priority ties between sources. An arbiter that uses a non-strict compare would present the higher-indexed source instead of the lowest one. It also targets the 0xFF mask value: a design that treats 0xFF as merely the least favoured priority would still raise valid when only masked sources are active. Priority truncation is checked with patterns that have ones in the dropped low bits, so a design that stores all 8 bits or pads with zeros reads back the wrong value. Finally, writes to unaligned offsets, to the gap region and to offsets just past the last entry must leave every entry unchanged; a loose address decode would alias them onto a real entry.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  localparam int DATA_W = 32;
  localparam int PRIO_W = 8;
  localparam int SRC_NUM_W = 24;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CFG   = 2'd1,
    SEL_DIAG  = 2'd2,
    SEL_ENTRY = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   wrEntry;
    logic   rdEn;
    rdSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 12,
  parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe,
  output logic [IDX_W-1:0]  entryIdx
);

  localparam logic [ADDR_W-1:0] CFG_OFF   = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] DIAG_OFF  = ADDR_W'('h004);
  localparam logic [ADDR_W-1:0] ENTRY_OFF = ADDR_W'('h800);
  localparam logic [ADDR_W-1:0] ENTRY_CNT = ADDR_W'(NUM_SRC);

  logic [ADDR_W-1:0] entryRel;
  logic [ADDR_W-1:0] entryWord;
  logic              cfgHit;
  logic              diagHit;
  logic              entryHit;

  always_comb begin
    entryRel  = busAddr - ENTRY_OFF;
    entryWord = entryRel >> 2;
    cfgHit    = (busAddr == CFG_OFF);
    diagHit   = (busAddr == DIAG_OFF);
    entryHit  = (busAddr >= ENTRY_OFF) && (entryRel[1:0] == 2'b00) &&
                (entryWord < ENTRY_CNT);
    entryIdx  = entryWord[IDX_W-1:0];
  end

  always_comb begin
    strobe.wrEntry = busWrEn && entryHit;
    strobe.rdEn    = busRdEn;
    if (cfgHit)        strobe.rdSel = SEL_CFG;
    else if (diagHit)  strobe.rdSel = SEL_DIAG;
    else if (entryHit) strobe.rdSel = SEL_ENTRY;
    else               strobe.rdSel = SEL_NONE;
  end

endmodule

// File: rtl/irq_src_dp.sv
module irq_src_dp
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int PRIO_BITS = 3,
  parameter int IRQ_BASE  = 16,
  parameter int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStrobe_t                     strobe,
  input  logic [IDX_W-1:0]                entryIdx,
  input  logic [DATA_W-1:0]               busWrData,
  input  logic [NUM_SRC-1:0]              irqIn,
  output logic [DATA_W-1:0]               busRdData,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]  prioFull
);

  localparam int PAD_W = PRIO_W - PRIO_BITS;
  localparam logic [DATA_W-1:0] CFG_WORD =
    {4'b0000, 4'(PRIO_BITS), 24'(IRQ_BASE)};

  logic [PRIO_BITS-1:0] prioQ [NUM_SRC];
  logic [PRIO_BITS-1:0] prioWr;
  logic [DATA_W-1:0]    rdWord;
  logic                 unusedWrBits;

  assign prioWr       = busWrData[PRIO_W-1 -: PRIO_BITS];
  assign unusedWrBits = ^busWrData;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prioQ[i] <= '1;
      end else if (strobe.wrEntry && (entryIdx == IDX_W'(i))) begin
        prioQ[i] <= prioWr;
      end
    end

    if (PAD_W == 0) begin : g_full
      assign prioFull[i] = prioQ[i];
    end else begin : g_pad
      assign prioFull[i] = {prioQ[i], {PAD_W{1'b1}}};
    end
  end

  always_comb begin
    rdWord = '0;
    unique case (strobe.rdSel)
      SEL_CFG:  rdWord = CFG_WORD;
      SEL_DIAG: rdWord = DATA_W'(irqIn);
      SEL_ENTRY: begin
        rdWord[31]  = irqIn[entryIdx];
        rdWord[29]  = irqIn[entryIdx];
        rdWord[7:0] = prioFull[entryIdx];
      end
      default:  rdWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdData <= '0;
    end else if (strobe.rdEn) begin
      busRdData <= rdWord;
    end
  end

endmodule

// File: rtl/irq_src_arb.sv
module irq_src_arb
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int IRQ_BASE = 16,
  parameter int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_SRC-1:0]             irqIn,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prioFull,
  output logic                           irqValid,
  output logic [SRC_NUM_W-1:0]           irqSrcNum,
  output logic [PRIO_W-1:0]              irqPrio
);

  localparam logic [PRIO_W-1:0] MASKED = '1;

  logic [PRIO_W-1:0] bestPrio;
  logic [IDX_W-1:0]  bestIdx;
  logic              anyHit;

  // Strict less-than keeps the earliest (lowest) index on ties, and
  // starting from the mask value excludes masked sources for free.
  always_comb begin
    bestPrio = MASKED;
    bestIdx  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (irqIn[i] && (prioFull[i] < bestPrio)) begin
        bestPrio = prioFull[i];
        bestIdx  = IDX_W'(i);
      end
    end
    anyHit = (bestPrio != MASKED);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqValid  <= 1'b0;
      irqSrcNum <= '0;
      irqPrio   <= MASKED;
    end else begin
      irqValid  <= anyHit;
      irqSrcNum <= SRC_NUM_W'(IRQ_BASE) + SRC_NUM_W'(bestIdx);
      irqPrio   <= bestPrio;
    end
  end

endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int PRIO_BITS = 3,
  parameter int IRQ_BASE  = 16,
  parameter int ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic              irqValid,
  output logic [23:0]       irqSrcNum,
  output logic [7:0]        irqPrio
);

  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  ctrlStrobe_t                     strobe;
  logic [IDX_W-1:0]                entryIdx;
  logic [NUM_SRC-1:0][PRIO_W-1:0]  prioFull;

  irq_src_ctrl #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W)
  ) u_ctrl (
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .busAddr  (busAddr),
    .strobe   (strobe),
    .entryIdx (entryIdx)
  );

  irq_src_dp #(
    .NUM_SRC   (NUM_SRC),
    .PRIO_BITS (PRIO_BITS),
    .IRQ_BASE  (IRQ_BASE),
    .IDX_W     (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .entryIdx  (entryIdx),
    .busWrData (busWrData),
    .irqIn     (irqIn),
    .busRdData (busRdData),
    .prioFull  (prioFull)
  );

  irq_src_arb #(
    .NUM_SRC  (NUM_SRC),
    .IRQ_BASE (IRQ_BASE),
    .IDX_W    (IDX_W)
  ) u_arb (
    .clk       (clk),
    .rstN      (rstN),
    .irqIn     (irqIn),
    .prioFull  (prioFull),
    .irqValid  (irqValid),
    .irqSrcNum (irqSrcNum),
    .irqPrio   (irqPrio)
  );

endmodule

// File: rtl/irq_src_chk.sv
module irq_src_chk #(
  parameter int NUM_SRC   = 8,
  parameter int PRIO_BITS = 3,
  parameter int IRQ_BASE  = 16,
  parameter int ADDR_W    = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               busRdEn,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [31:0]        busRdData,
  input logic [NUM_SRC-1:0] irqIn,
  input logic               irqValid,
  input logic [23:0]        irqSrcNum,
  input logic [7:0]         irqPrio
);

  localparam logic [31:0] CFG_WORD = {4'b0000, 4'(PRIO_BITS), 24'(IRQ_BASE)};

  p_cfg_word_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(0)) |=> (busRdData == CFG_WORD));

  p_diag_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(4)) |=> ((busRdData >> NUM_SRC) == 32'd0));

  p_no_masked_win_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (irqPrio != 8'hFF));

  p_num_in_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> ((irqSrcNum >= 24'(IRQ_BASE)) &&
                  (irqSrcNum < 24'(IRQ_BASE + NUM_SRC))));

  p_valid_needs_input_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (|$past(irqIn)));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(busRdEn)) |-> $stable(busRdData));

endmodule

bind irq_src_bank irq_src_chk #(
  .NUM_SRC   (NUM_SRC),
  .PRIO_BITS (PRIO_BITS),
  .IRQ_BASE  (IRQ_BASE),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busRdEn   (busRdEn),
  .busAddr   (busAddr),
  .busRdData (busRdData),
  .irqIn     (irqIn),
  .irqValid  (irqValid),
  .irqSrcNum (irqSrcNum),
  .irqPrio   (irqPrio)
);

// File: tb/tb_irq_src_bank.sv
`timescale 1ns/1ps
module tb_irq_src_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [7:0]  irqIn = '0;
  logic        irqValid;
  logic [23:0] irqSrcNum;
  logic [7:0]  irqPrio;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  irq_src_bank dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .irqIn(irqIn), .irqValid(irqValid), .irqSrcNum(irqSrcNum),
    .irqPrio(irqPrio)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(posedge clk); #1;
    d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic setIrq(input logic [7:0] v);
    @(negedge clk);
    irqIn = v;
    @(posedge clk); #1;
  endtask

  task automatic settle();
    @(posedge clk); #1;
  endtask

  task automatic chkOut(input string tag, input logic v, input logic [23:0] n, input logic [7:0] p);
    chk({tag, " valid"}, 32'(irqValid), 32'(v));
    if (v) begin
      chk({tag, " num"}, 32'(irqSrcNum), 32'(n));
      chk({tag, " prio"}, 32'(irqPrio), 32'(p));
    end
  endtask

  task automatic testReset();
    logic [31:0] d;
    chk("R5 valid after reset", 32'(irqValid), 32'd0);
    chk("R5 rdData after reset", busRdData, 32'd0);
    busRead(12'h80C, d);
    chk("R5 entry3 prio after reset", d, 32'h0000_00FF);
    setIrq(8'hFF);
    settle();
    chkOut("R6 all masked", 1'b0, 24'd0, 8'd0);
    setIrq(8'h00);
  endtask

  task automatic testConfig();
    logic [31:0] d;
    busRead(12'h000, d);
    chk("R1 config word", d, 32'h0300_0010);
    busWrite(12'h000, 32'h0000_0000);
    busRead(12'h000, d);
    chk("R1 config after write", d, 32'h0300_0010);
    @(negedge clk); busAddr = 12'h004;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 read data holds", busRdData, 32'h0300_0010);
  endtask

  task automatic testDiag();
    logic [31:0] d;
    setIrq(8'hA5);
    busRead(12'h004, d);
    chk("R2 diag levels", d, 32'h0000_00A5);
    busWrite(12'h004, 32'hFFFF_FFFF);
    setIrq(8'h3C);
    busRead(12'h004, d);
    chk("R2 diag after write", d, 32'h0000_003C);
    setIrq(8'h00);
  endtask

  task automatic testEntry();
    logic [31:0] d;
    setIrq(8'h04);
    busRead(12'h808, d);
    chk("R3 entry2 level high", d, 32'hA000_00FF);
    busWrite(12'h808, 32'hFFFF_FFFF);
    busRead(12'h808, d);
    chk("R3 reserved bits stay zero", d, 32'hA000_00FF);
    busWrite(12'h808, 32'h0000_0000);
    busRead(12'h808, d);
    chk("R4 write 0x00 reads 0x1F", d, 32'hA000_001F);
    busWrite(12'h808, 32'h0000_00A5);
    busRead(12'h808, d);
    chk("R4 write 0xA5 reads 0xBF", d, 32'hA000_00BF);
    setIrq(8'h00);
    busRead(12'h808, d);
    chk("R3 entry2 level low", d, 32'h0000_00BF);
  endtask

  task automatic testArb();
    busWrite(12'h808, 32'h0000_0060);
    busWrite(12'h814, 32'h0000_0040);
    setIrq(8'h24);
    chkOut("R7 lower value wins", 1'b1, 24'd21, 8'h5F);
    busWrite(12'h804, 32'h0000_0040);
    setIrq(8'h26);
    chkOut("R7 tie to lowest index", 1'b1, 24'd17, 8'h5F);
    setIrq(8'h24);
    chkOut("R7 after drop", 1'b1, 24'd21, 8'h5F);
    busWrite(12'h814, 32'h0000_00FF);
    settle();
    chkOut("R6 masked skipped", 1'b1, 24'd18, 8'h7F);
    setIrq(8'h20);
    chkOut("R6 only masked active", 1'b0, 24'd0, 8'd0);
    setIrq(8'h00);
    chkOut("R7 idle", 1'b0, 24'd0, 8'd0);
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    busWrite(12'h008, 32'h1234_5678);
    busRead(12'h008, d);
    chk("R8 gap reads zero", d, 32'h0);
    busWrite(12'h802, 32'h0000_0000);
    busRead(12'h802, d);
    chk("R8 unaligned reads zero", d, 32'h0);
    busWrite(12'h820, 32'h0000_0000);
    busRead(12'h820, d);
    chk("R8 past last entry reads zero", d, 32'h0);
    busRead(12'h800, d);
    chk("R8 entry0 untouched", d, 32'h0000_00FF);
    busRead(12'h81C, d);
    chk("R8 entry7 untouched", d, 32'h0000_00FF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testConfig();
    testDiag();
    testEntry();
    testArb();
    testUnmapped();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #800000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule